// File: doc/BRIEF.md
# Per-Core Local Interrupt Aggregator

This block collects the interrupt sources that belong to each core of a four-core cluster. It drives one level interrupt request per core and exposes one readable pending word per core.

Each core has four architectural timer lines. The cluster has one performance-monitor line per core, one fast peripheral line that only core 0 receives, and one mailbox-nonzero indication per core. Software enables sources through a small byte-addressed register port. The port holds a timer enable word and a mailbox enable word for each core, plus a monitor routing mask. That mask is changed only through a write-one-to-set address and a write-one-to-clear address, so no read-modify-write is needed.

A core's request is high whenever any enabled source for that core is active. All sources are level sensitive. The pending word lets the interrupt handler find which source fired.

Top module: `core_irq_fanin`

## Requirements
- R1: Reset is synchronous and active high. After reset every enable is 0, the monitor routing mask is 0, every `irq` bit is 0, and every register reads 0.
- R2: The timer enable word of core c is at byte address 0x00+4c. Bits 3:0 are stored on a write and read back, and bits 31:4 read as 0.
- R3: Pending bit i (i = 0..3) of core c is 1 exactly when timer enable bit i of core c is 1 and timer line i of core c is high. Core c's timer lines are `tmr_lvl[4c+3:4c]`.
- R4: A write to 0x10 ORs `wr_data[3:0]` into the monitor routing mask, and a write to 0x14 clears each mask bit whose data bit is 1. Reading 0x10 returns the mask in bits 3:0 with all other bits 0, and reading 0x14 returns 0.
- R5: Pending bit 9 of core c equals mask bit c AND `pmu_lvl[c]`.
- R6: The mailbox enable word of core c is at 0x20+4c, and only bit 0 is stored. Pending bit 4 of core c equals that bit AND `mbx_nz[c]`.
- R7: Pending bit 8 of core 0 follows `fast_lvl` with no enable. Bit 8 of every other core's pending word is 0.
- R8: `irq[c]` is a register. It is high one clock after core c's pending word is nonzero.
- R9: The pending word of core c is read at 0x30+4c. Bits 7:5 and 31:10 read as 0. Reads return data one clock after `rd_en`, and any address not listed here, or not a multiple of 4, reads 0.
- R10: Writes to pending addresses, unlisted addresses or addresses that are not a multiple of 4 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Read data, one clock after rd_en |
| tmr_lvl | input | 16 | Timer lines, four per core |
| pmu_lvl | input | 4 | Performance-monitor line per core |
| fast_lvl | input | 1 | Shared fast peripheral line |
| mbx_nz | input | 4 | Mailbox 0 nonzero per core |
| irq | output | 4 | Interrupt request per core |

## Verification
The hardest situation to reach is a source that is active and enabled for one core while another core's monitor routing bit is set and cleared in the same random stream. Only then do the set and clear addresses show that they touch individual bits and not the whole mask. Random writes land on every address class, including misaligned and read-only ones. The random source lines keep changing under the writes, so masked and unmasked combinations occur for every core. After each step the bench reads a random address and compares every `irq` bit against a model built from the requirements.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int NUM_TMR = 4;
  localparam int PB_MBOX = 4;
  localparam int PB_FAST = 8;
  localparam int PB_PMU  = 9;

  localparam logic [3:0] RG_TMR = 4'h0;
  localparam logic [3:0] RG_PMU = 4'h1;
  localparam logic [3:0] RG_MBX = 4'h2;
  localparam logic [3:0] RG_PND = 4'h3;

  typedef struct packed {
    logic       hit;
    logic [3:0] region;
    logic [1:0] slot;
  } dec_t;

  function automatic dec_t decode(input logic [ADDR_W-1:0] a);
    dec_t d;
    d.hit    = (a[1:0] == 2'b00);
    d.region = a[ADDR_W-1:4];
    d.slot   = a[3:2];
    return d;
  endfunction
endpackage

// File: rtl/lirq_ctrl_regs.sv
module lirq_ctrl_regs
  import lirq_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [DATA_W-1:0]                  wr_data,
  output logic [NUM_CORES-1:0][NUM_TMR-1:0]  tmr_en,
  output logic [NUM_CORES-1:0]               mbx_en,
  output logic [NUM_CORES-1:0]               pmu_route
);
  dec_t wd;
  assign wd = decode(wr_addr);

  logic wr_ok;
  assign wr_ok = wr_en && wd.hit;

  logic unused_wr_hi;
  assign unused_wr_hi = ^wr_data[DATA_W-1:NUM_TMR];

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    always_ff @(posedge clk) begin
      if (rst) begin
        tmr_en[c] <= '0;
        mbx_en[c] <= 1'b0;
      end else begin
        if (wr_ok && wd.region == RG_TMR && wd.slot == 2'(c))
          tmr_en[c] <= wr_data[NUM_TMR-1:0];
        if (wr_ok && wd.region == RG_MBX && wd.slot == 2'(c))
          mbx_en[c] <= wr_data[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pmu_route <= '0;
    end else if (wr_ok && wd.region == RG_PMU) begin
      if (wd.slot == 2'd0)
        pmu_route <= pmu_route | wr_data[NUM_CORES-1:0];
      else if (wd.slot == 2'd1)
        pmu_route <= pmu_route & ~wr_data[NUM_CORES-1:0];
    end
  end
endmodule

// File: rtl/lirq_pend_core.sv
module lirq_pend_core
  import lirq_pkg::*;
#(
  parameter bit HAS_FAST = 1'b0
) (
  input  logic [NUM_TMR-1:0] tmr_lvl,
  input  logic [NUM_TMR-1:0] tmr_en,
  input  logic               mbx_nz,
  input  logic               mbx_en,
  input  logic               fast_lvl,
  input  logic               pmu_lvl,
  input  logic               pmu_route,
  output logic [DATA_W-1:0]  pend
);
  logic fast_bit;

  if (HAS_FAST) begin : g_fast
    assign fast_bit = fast_lvl;
  end else begin : g_nofast
    logic unused_fast;
    assign unused_fast = fast_lvl;
    assign fast_bit    = 1'b0;
  end

  always_comb begin
    pend                 = '0;
    pend[NUM_TMR-1:0]    = tmr_lvl & tmr_en;
    pend[PB_MBOX]        = mbx_nz & mbx_en;
    pend[PB_FAST]        = fast_bit;
    pend[PB_PMU]         = pmu_lvl & pmu_route;
  end
endmodule

// File: rtl/lirq_rd_mux.sv
module lirq_rd_mux
  import lirq_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               rd_en,
  input  logic [ADDR_W-1:0]                  rd_addr,
  input  logic [NUM_CORES-1:0][NUM_TMR-1:0]  tmr_en,
  input  logic [NUM_CORES-1:0]               mbx_en,
  input  logic [NUM_CORES-1:0]               pmu_route,
  input  logic [NUM_CORES-1:0][DATA_W-1:0]   pend,
  output logic [DATA_W-1:0]                  rd_data
);
  dec_t rd;
  assign rd = decode(rd_addr);

  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (rd.hit) begin
      for (int c = 0; c < NUM_CORES; c++) begin
        if (rd.slot == 2'(c)) begin
          case (rd.region)
            RG_TMR:  sel = DATA_W'(tmr_en[c]);
            RG_MBX:  sel = DATA_W'(mbx_en[c]);
            RG_PND:  sel = pend[c];
            default: ;
          endcase
        end
      end
      if (rd.region == RG_PMU && rd.slot == 2'd0)
        sel = DATA_W'(pmu_route);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= sel;
  end
endmodule

// File: rtl/core_irq_fanin.sv
module core_irq_fanin
  import lirq_pkg::*;
#(
  parameter int NUM_CORES = 4,
  localparam int TMR_BITS = NUM_CORES * NUM_TMR
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  input  logic [TMR_BITS-1:0]   tmr_lvl,
  input  logic [NUM_CORES-1:0]  pmu_lvl,
  input  logic                  fast_lvl,
  input  logic [NUM_CORES-1:0]  mbx_nz,
  output logic [NUM_CORES-1:0]  irq
);
  logic [NUM_CORES-1:0][NUM_TMR-1:0] tmr_en;
  logic [NUM_CORES-1:0]              mbx_en;
  logic [NUM_CORES-1:0]              pmu_route;
  logic [NUM_CORES-1:0][DATA_W-1:0]  pend;

  lirq_ctrl_regs #(.NUM_CORES(NUM_CORES)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .tmr_en    (tmr_en),
    .mbx_en    (mbx_en),
    .pmu_route (pmu_route)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_pend
    lirq_pend_core #(.HAS_FAST(c == 0)) u_pend (
      .tmr_lvl   (tmr_lvl[c*NUM_TMR +: NUM_TMR]),
      .tmr_en    (tmr_en[c]),
      .mbx_nz    (mbx_nz[c]),
      .mbx_en    (mbx_en[c]),
      .fast_lvl  (fast_lvl),
      .pmu_lvl   (pmu_lvl[c]),
      .pmu_route (pmu_route[c]),
      .pend      (pend[c])
    );

    always_ff @(posedge clk) begin
      if (rst) irq[c] <= 1'b0;
      else     irq[c] <= |pend[c];
    end
  end

  lirq_rd_mux #(.NUM_CORES(NUM_CORES)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .tmr_en    (tmr_en),
    .mbx_en    (mbx_en),
    .pmu_route (pmu_route),
    .pend      (pend),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/lirq_chk.sv
module lirq_chk
  import lirq_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              wr_en,
  input logic [ADDR_W-1:0]                 wr_addr,
  input logic [DATA_W-1:0]                 wr_data,
  input logic [NUM_CORES-1:0]              irq,
  input logic [NUM_CORES-1:0]              pmu_route,
  input logic [NUM_CORES-1:0][DATA_W-1:0]  pend
);
  p_rst_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq == '0 && pmu_route == '0));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_c
    p_irq_follow_r8: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (irq[c] == (|$past(pend[c]))));

    p_spare_zero_r9: assert property (@(posedge clk) disable iff (rst)
      (pend[c][7:5] == '0 && pend[c][DATA_W-1:10] == '0));

    p_route_set_r4: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == 8'h10 && wr_data[c]) |=> pmu_route[c]);

    p_route_clr_r4: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == 8'h14 && wr_data[c]) |=> !pmu_route[c]);

    if (c > 0) begin : g_nf
      p_fast_core0_r7: assert property (@(posedge clk) disable iff (rst)
        pend[c][PB_FAST] == 1'b0);
    end
  end
endmodule

bind core_irq_fanin lirq_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .irq       (irq),
  .pmu_route (pmu_route),
  .pend      (pend)
);

// File: tb/test_core_irq_fanin.sv
`timescale 1ns/1ps
module test_core_irq_fanin;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [15:0] tmr_lvl = '0;
  logic [3:0]  pmu_lvl = '0;
  logic        fast_lvl = 1'b0;
  logic [3:0]  mbx_nz = '0;
  logic [3:0]  irq;

  int checks = 0;
  int errors = 0;

  logic [3:0] m_tmr [NC];
  logic [3:0] m_pmu;
  logic [3:0] m_mbx;

  always #5 clk = ~clk;

  core_irq_fanin #(.NUM_CORES(NC)) i_core_irq_fanin (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .tmr_lvl(tmr_lvl),
    .pmu_lvl(pmu_lvl), .fast_lvl(fast_lvl), .mbx_nz(mbx_nz), .irq(irq)
  );

  function automatic logic [31:0] exp_pend(input int c);
    logic [31:0] r = '0;
    r[3:0] = m_tmr[c] & tmr_lvl[c*4 +: 4];
    r[4]   = m_mbx[c] & mbx_nz[c];
    if (c == 0) r[8] = fast_lvl;
    r[9]   = m_pmu[c] & pmu_lvl[c];
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    int s = int'(a[3:2]);
    if (a[1:0] != 2'b00) return '0;
    case (a[7:4])
      4'h0: return {28'h0, m_tmr[s]};
      4'h1: return (s == 0) ? {28'h0, m_pmu} : 32'h0;
      4'h2: return {31'h0, m_mbx[s]};
      4'h3: return exp_pend(s);
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a[1:0] == 2'b00) begin
      case (a[7:4])
        4'h0: m_tmr[a[3:2]] = d[3:0];
        4'h1: if (a[3:2] == 2'd0) m_pmu = m_pmu | d[3:0];
              else if (a[3:2] == 2'd1) m_pmu = m_pmu & ~d[3:0];
        4'h2: m_mbx[a[3:2]] = d[0];
        default: ;
      endcase
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  function automatic logic [7:0] rnd_addr();
    logic [7:0] a;
    a[7:4] = 4'(($urandom % 6));
    a[3:2] = 2'($urandom);
    a[1:0] = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
    return a;
  endfunction

  task automatic check_irqs(input string req);
    for (int c = 0; c < NC; c++)
      chk(req, {31'h0, irq[c]}, {31'h0, |exp_pend(c)});
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    for (int c = 0; c < NC; c++) m_tmr[c] = '0;
    m_pmu = '0; m_mbx = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state, with sources active but masked
    tmr_lvl = '1; pmu_lvl = '1; mbx_nz = '1;
    @(negedge clk);
    chk("R1 irq after reset", {28'h0, irq}, 32'h0);
    for (int c = 0; c < NC; c++) begin
      rd(8'(c*4), d);        chk("R1 timer enable", d, 32'h0);
      rd(8'(8'h20 + c*4), d); chk("R1 mailbox enable", d, 32'h0);
    end
    rd(8'h10, d); chk("R1 routing mask", d, 32'h0);
    tmr_lvl = '0; pmu_lvl = '0; mbx_nz = '0;

    // R2: timer word keeps only bits 3:0
    wr(8'h04, 32'hFFFF_FFFA); rd(8'h04, d); chk("R2 timer readback", d, 32'h0000_000A);

    // R4: set and clear addresses act per bit
    wr(8'h10, 32'h5); rd(8'h10, d); chk("R4 set", d, 32'h5);
    wr(8'h10, 32'h2); rd(8'h10, d); chk("R4 set accumulate", d, 32'h7);
    wr(8'h14, 32'h4); rd(8'h10, d); chk("R4 clear", d, 32'h3);
    rd(8'h14, d); chk("R4 clear address reads zero", d, 32'h0);

    // R10: writes to pending, misaligned and unlisted addresses are ignored
    wr(8'h05, 32'hF); wr(8'h30, 32'hFFFF_FFFF); wr(8'h50, 32'hF);
    rd(8'h04, d); chk("R10 timer word unchanged", d, 32'h0000_000A);
    rd(8'h10, d); chk("R10 routing mask unchanged", d, 32'h3);
    rd(8'h50, d); chk("R9 unlisted reads zero", d, 32'h0);

    // R7: fast line reaches core 0 only, unmasked
    fast_lvl = 1'b1;
    rd(8'h30, d); chk("R7 core0 fast bit", d, 32'h100);
    rd(8'h34, d); chk("R7 core1 no fast bit", d, exp_pend(1));
    fast_lvl = 1'b0;

    // R8: one-clock latency from source to irq
    wr(8'h28, 32'h1);
    @(negedge clk);
    mbx_nz[2] = 1'b1;
    chk("R8 irq not yet", {31'h0, irq[2]}, 32'h0);
    @(negedge clk);
    chk("R8 irq after one clock", {31'h0, irq[2]}, 32'h1);
    rd(8'h38, d); chk("R6 mailbox pending", d, 32'h10);
    mbx_nz = '0;

    // R3 R5 R6 R9: random mix of sources, enables and addresses
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      tmr_lvl  = 16'($urandom);
      pmu_lvl  = 4'($urandom);
      mbx_nz   = 4'($urandom);
      fast_lvl = 1'($urandom);
      wr(rnd_addr(), $urandom);
      begin
        logic [7:0] a = rnd_addr();
        rd(a, d);
        chk("R3 R5 R6 R9 random read", d, exp_rd(a));
      end
      check_irqs("R8 random irq");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule